// File: doc/BRIEF.md
# DMA Request Alignment Screen

This block sits in front of a DMA transfer controller and screens every transfer request before it reaches it. Each request carries an option word, a source and a destination byte address, and a source and a destination index. Bits of the option word choose, per side, between incrementing addressing and constant (fixed) addressing. A side in constant mode must have its address and its index on a 32-byte boundary. A request that meets this rule is passed on unchanged. A request that breaks it is answered with a reject and never reaches the controller.

The block also holds a three-bit sticky error status. The bits record bus errors reported by the data path, accesses to invalid configuration addresses, and rejected requests. Each class has its own enable bit. When an enabled status bit goes from clear to set, the block raises a single-cycle interrupt pulse. Software reads the status and clears bits by writing ones to a clear input.

The request path is a three-state machine. In `ST_IDLE` the block is ready and accepts a request. Acceptance moves it to `ST_FWD` (the request conforms) or to `ST_REJ` (the request violates the rule). `ST_FWD` holds the request on the forward port until the controller takes it, then returns to `ST_IDLE`. `ST_REJ` shows the reject for one cycle and returns to `ST_IDLE`.

Top module: `dma_req_screen`

## Requirements
- R1: Option bit 0 sets the source addressing mode and option bit 1 sets the destination addressing mode, with 1 meaning constant and 0 meaning increment. The two sides are judged independently.
- R2: A side in increment mode imposes no alignment rule. A request whose constant sides all conform is forwarded, however its increment sides are aligned.
- R3: A constant-mode side violates the rule if any of the low 5 bits of its address or of its index is nonzero. A request with any violating side is rejected.
- R4: A conforming request appears on the forward port one cycle after acceptance, with all five fields unchanged, including the FIFO width code in option bits 10:8. It is held stable until `fwd_ready`, and `req_ready` stays low while it is held.
- R5: A rejected request raises `rej_valid` for exactly one cycle, starting one cycle after acceptance. `fwd_valid` never rises for that request.
- R6: Error status bit 2 is set by every rejected request, bit 0 by `bus_err`, and bit 1 by `cfg_err`. Each bit stays set until it is cleared, whether or not its enable is on.
- R7: Writing 1 to a bit of `err_clr` clears that status bit on the next edge. If a new error of that class arrives in the same cycle, the bit stays set.
- R8: `err_irq` is high for exactly one cycle, the cycle after a status bit goes from 0 to 1 while its `err_en` bit is 1. An error whose enable is off raises no pulse, and neither does an error whose bit is already set.
- R9: After reset, `req_ready` is 1, `fwd_valid`, `rej_valid` and `err_irq` are 0, and the status is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_opt | input | OPT_W | Option word (mode bits 1:0, FIFO width code 10:8) |
| req_src_addr | input | ADDR_W | Source byte address |
| req_dst_addr | input | ADDR_W | Destination byte address |
| req_src_idx | input | IDX_W | Source index |
| req_dst_idx | input | IDX_W | Destination index |
| fwd_valid | output | 1 | Conforming request held for the controller |
| fwd_ready | input | 1 | Controller takes the forwarded request |
| fwd_opt | output | OPT_W | Forwarded option word |
| fwd_src_addr | output | ADDR_W | Forwarded source address |
| fwd_dst_addr | output | ADDR_W | Forwarded destination address |
| fwd_src_idx | output | IDX_W | Forwarded source index |
| fwd_dst_idx | output | IDX_W | Forwarded destination index |
| rej_valid | output | 1 | One-cycle reject response |
| bus_err | input | 1 | Bus error reported by source or destination |
| cfg_err | input | 1 | Invalid configuration address accessed |
| err_en | input | 3 | Per-class interrupt enables |
| err_clr | input | 3 | Write-one-to-clear strobes for status |
| err_stat | output | 3 | Sticky error status (0 bus, 1 config, 2 request) |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The bench builds the block with its defaults: a 16-bit option word, 32-bit addresses, 16-bit indexes and an alignment exponent of 5. These widths let the vectors set each of the low five bits on its own, and also set bits above the boundary, such as 0x20 and 0x40 offsets, that must pass. The full FIFO width field in bits 10:8 fits, so pass-through of a nonzero width code is checked on constant-mode requests. With three error classes, the bench can set two classes at once and can run a same-cycle clear against a class that is not involved.

// File: rtl/dma_screen_pkg.sv
package dma_screen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_REJ  = 2'd2
    } scr_state_e;

    localparam int MODE_BIT_SRC = 0;
    localparam int MODE_BIT_DST = 1;

    localparam int NUM_ERR  = 3;
    localparam int ERR_BUS  = 0;
    localparam int ERR_CFG  = 1;
    localparam int ERR_REQ  = 2;

endpackage

// File: rtl/dma_align_rule.sv
module dma_align_rule
    import dma_screen_pkg::*;
#(
    parameter int OPT_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int ALIGN_LG2 = 5
) (
    input  logic [OPT_W-1:0]  opt,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic              violate
);

    localparam int NSIDE = 2;

    logic [NSIDE-1:0] side_bad;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic                 is_const;
        logic [ALIGN_LG2-1:0] a_low;
        logic [ALIGN_LG2-1:0] i_low;

        assign is_const = (s == 0) ? opt[MODE_BIT_SRC] : opt[MODE_BIT_DST];
        assign a_low    = (s == 0) ? src_addr[ALIGN_LG2-1:0] : dst_addr[ALIGN_LG2-1:0];
        assign i_low    = (s == 0) ? src_idx[ALIGN_LG2-1:0]  : dst_idx[ALIGN_LG2-1:0];
        assign side_bad[s] = is_const && ((a_low != '0) || (i_low != '0));
    end

    assign violate = |side_bad;

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status #(
    parameter int NERR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] evt,
    input  logic [NERR-1:0] clr,
    input  logic [NERR-1:0] en,
    output logic [NERR-1:0] stat,
    output logic            irq
);

    logic [NERR-1:0] stat_q;
    logic [NERR-1:0] stat_d;
    logic [NERR-1:0] fresh;
    logic            irq_q;

    always_comb begin
        stat_d = (stat_q & ~clr) | evt;
        fresh  = evt & ~stat_q & en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= |fresh;
        end
    end

    assign stat = stat_q;
    assign irq  = irq_q;

endmodule

// File: rtl/dma_req_screen.sv
module dma_req_screen
    import dma_screen_pkg::*;
#(
    parameter int OPT_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int ALIGN_LG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OPT_W-1:0]  req_opt,
    input  logic [ADDR_W-1:0] req_src_addr,
    input  logic [ADDR_W-1:0] req_dst_addr,
    input  logic [IDX_W-1:0]  req_src_idx,
    input  logic [IDX_W-1:0]  req_dst_idx,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [OPT_W-1:0]  fwd_opt,
    output logic [ADDR_W-1:0] fwd_src_addr,
    output logic [ADDR_W-1:0] fwd_dst_addr,
    output logic [IDX_W-1:0]  fwd_src_idx,
    output logic [IDX_W-1:0]  fwd_dst_idx,
    output logic              rej_valid,
    input  logic              bus_err,
    input  logic              cfg_err,
    input  logic [2:0]        err_en,
    input  logic [2:0]        err_clr,
    output logic [2:0]        err_stat,
    output logic              err_irq
);

    scr_state_e state_q, state_d;
    logic       accept;
    logic       violate;
    logic [NUM_ERR-1:0] err_evt;

    logic [OPT_W-1:0]  opt_q;
    logic [ADDR_W-1:0] sa_q, da_q;
    logic [IDX_W-1:0]  si_q, di_q;

    dma_align_rule #(
        .OPT_W(OPT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LG2(ALIGN_LG2)
    ) u_rule (
        .opt(req_opt), .src_addr(req_src_addr), .dst_addr(req_dst_addr),
        .src_idx(req_src_idx), .dst_idx(req_dst_idx), .violate(violate)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = violate ? ST_REJ : ST_FWD;
            ST_FWD:  if (fwd_ready) state_d = ST_IDLE;
            ST_REJ:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= '0; sa_q <= '0; da_q <= '0; si_q <= '0; di_q <= '0;
        end else if (accept) begin
            opt_q <= req_opt;
            sa_q  <= req_src_addr;
            da_q  <= req_dst_addr;
            si_q  <= req_src_idx;
            di_q  <= req_dst_idx;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        fwd_valid = 1'b0;
        rej_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_FWD:  fwd_valid = 1'b1;
            ST_REJ:  rej_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign fwd_opt      = opt_q;
    assign fwd_src_addr = sa_q;
    assign fwd_dst_addr = da_q;
    assign fwd_src_idx  = si_q;
    assign fwd_dst_idx  = di_q;

    always_comb begin
        err_evt          = '0;
        err_evt[ERR_BUS] = bus_err;
        err_evt[ERR_CFG] = cfg_err;
        err_evt[ERR_REQ] = accept && violate;
    end

    dma_err_status #(.NERR(NUM_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(err_clr), .en(err_en),
        .stat(err_stat), .irq(err_irq)
    );

endmodule

// File: rtl/dma_req_screen_chk.sv
module dma_req_screen_chk #(
    parameter int OPT_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             fwd_valid,
    input logic             fwd_ready,
    input logic [OPT_W-1:0] fwd_opt,
    input logic [ADDR_W-1:0] fwd_src_addr,
    input logic             rej_valid,
    input logic [2:0]       err_en,
    input logic [2:0]       err_clr,
    input logic [2:0]       err_stat,
    input logic             err_irq
);

    assert_fwd_rej_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && rej_valid));

    assert_rej_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |=> !rej_valid);

    assert_fwd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_opt) && $stable(fwd_src_addr)));

    assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid || rej_valid) |-> !req_ready);

    assert_rej_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> err_stat[2]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_stat & $past(err_stat & ~err_clr)) == $past(err_stat & ~err_clr)));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> |(err_stat & ~$past(err_stat) & $past(err_en)));

endmodule

bind dma_req_screen dma_req_screen_chk #(.OPT_W(OPT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_opt(fwd_opt), .fwd_src_addr(fwd_src_addr),
    .rej_valid(rej_valid), .err_en(err_en), .err_clr(err_clr),
    .err_stat(err_stat), .err_irq(err_irq)
);

// File: tb/sim_dma_req_screen.sv
`timescale 1ns/1ps
module sim_dma_req_screen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_opt = '0;
    logic [31:0] req_src_addr = '0, req_dst_addr = '0;
    logic [15:0] req_src_idx = '0, req_dst_idx = '0;
    logic        fwd_valid, fwd_ready = 1'b0;
    logic [15:0] fwd_opt;
    logic [31:0] fwd_src_addr, fwd_dst_addr;
    logic [15:0] fwd_src_idx, fwd_dst_idx;
    logic        rej_valid;
    logic        bus_err = 1'b0, cfg_err = 1'b0;
    logic [2:0]  err_en = 3'b111, err_clr = 3'b000;
    logic [2:0]  err_stat;
    logic        err_irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_req_screen u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {opt, src_addr, dst_addr, src_idx, dst_idx, expect_reject}
    localparam logic [112:0] VECS [0:7] = '{
        {16'h0000, 32'h0000_1003, 32'h0000_2007, 16'h0003, 16'h0005, 1'b0},
        {16'h0301, 32'h0000_1000, 32'h0000_2003, 16'h0020, 16'h0007, 1'b0},
        {16'h0001, 32'h0000_1010, 32'h0000_2000, 16'h0000, 16'h0000, 1'b1},
        {16'h0001, 32'h0000_1000, 32'h0000_2000, 16'h0010, 16'h0000, 1'b1},
        {16'h0002, 32'h0000_1000, 32'h0000_2001, 16'h0000, 16'h0000, 1'b1},
        {16'h0502, 32'h0000_0003, 32'h0000_0040, 16'h0001, 16'h0040, 1'b0},
        {16'h0003, 32'h0000_1000, 32'h0000_2000, 16'h0020, 16'h0021, 1'b1},
        {16'h0703, 32'h0000_1020, 32'h0000_3fe0, 16'h0060, 16'h0fe0, 1'b0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 ready", req_ready, 1);
        chk("R9 fwd", fwd_valid, 0);
        chk("R9 rej", rej_valid, 0);
        chk("R9 stat", err_stat, 0);
        chk("R9 irq", err_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after release", req_ready, 1);

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 8; i++) begin
            logic [112:0] v;
            v = VECS[i];
            req_opt = v[112:97]; req_src_addr = v[96:65]; req_dst_addr = v[64:33];
            req_src_idx = v[32:17]; req_dst_idx = v[16:1];
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            if (v[0]) begin
                chk("R3 R5 reject raised", rej_valid, 1);
                chk("R5 no forward", fwd_valid, 0);
                chk("R6 request error flag", err_stat[2], 1);
                chk("R8 irq on fresh request error", err_irq, 1);
                @(negedge clk);
                chk("R5 reject single cycle", rej_valid, 0);
                chk("R5 no forward later", fwd_valid, 0);
                chk("R8 irq single cycle", err_irq, 0);
                err_clr = 3'b100;
                @(negedge clk);
                err_clr = 3'b000;
                chk("R7 cleared", err_stat, 0);
            end else begin
                chk("R1 R2 forwarded", fwd_valid, 1);
                chk("R5 no reject", rej_valid, 0);
                chk("R4 not ready while held", req_ready, 0);
                chk("R4 opt unchanged", fwd_opt, v[112:97]);
                chk("R4 src addr", fwd_src_addr, v[96:65]);
                chk("R4 dst addr", fwd_dst_addr, v[64:33]);
                chk("R4 src idx", fwd_src_idx, v[32:17]);
                chk("R4 dst idx", fwd_dst_idx, v[16:1]);
                chk("R6 no error", err_stat, 0);
                @(negedge clk);
                chk("R4 held under backpressure", fwd_valid, 1);
                chk("R4 opt still", fwd_opt, v[112:97]);
                fwd_ready = 1'b1;
                @(negedge clk);
                fwd_ready = 1'b0;
                chk("R4 released", fwd_valid, 0);
                chk("R4 ready again", req_ready, 1);
            end
        end

        // R6 R8: bus error with enable on
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
        chk("R6 bus flag", err_stat, 3'b001);
        chk("R8 bus pulse", err_irq, 1);
        @(negedge clk);
        chk("R8 pulse ends", err_irq, 0);
        chk("R6 bus sticky", err_stat, 3'b001);
        // R8: repeat of a set bit gives no pulse
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
        chk("R8 no pulse for set bit", err_irq, 0);

        // R8: config error with enable off still records, no pulse
        err_en = 3'b101;
        cfg_err = 1'b1;
        @(negedge clk);
        cfg_err = 1'b0;
        chk("R6 cfg flag with enable off", err_stat, 3'b011);
        chk("R8 no pulse when disabled", err_irq, 0);
        err_en = 3'b111;

        // R7: clear bit 1 only
        err_clr = 3'b010;
        @(negedge clk);
        err_clr = 3'b000;
        chk("R7 clear one bit", err_stat, 3'b001);

        // R7: error and clear in the same cycle, error wins
        bus_err = 1'b1;
        err_clr = 3'b001;
        @(negedge clk);
        bus_err = 1'b0;
        err_clr = 3'b000;
        chk("R7 new error beats clear", err_stat, 3'b001);
        chk("R8 no pulse, bit never dropped", err_irq, 0);

        // R7 R8: clear all, then two classes at once give one pulse
        err_clr = 3'b111;
        @(negedge clk);
        err_clr = 3'b000;
        chk("R7 clear all", err_stat, 0);
        bus_err = 1'b1; cfg_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0; cfg_err = 1'b0;
        chk("R6 two classes", err_stat, 3'b011);
        chk("R8 pulse on two", err_irq, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", err_irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule